// File: doc/BRIEF.md
# Multi-Drop Colour Command Receiver

This block sits behind a UART byte receiver on a serial bus that several driver boards share. It collects received bytes into fixed ten-byte set-colour packets. When the tenth byte lands, the packet is checked. If the command code is right and the logical channel falls inside this board's window, four 16-bit colour values are written into the group of four raw-channel registers that belongs to that logical channel. The writes use a plain write-enable, address and data port. Each packet starts with a command byte and a channel byte, followed by red, green, blue and white values.

Framing does not rely on any marker byte. The byte position goes back to zero after every tenth byte. It also goes back to zero when the bus has been quiet for a set time, so a board that joins mid-packet or loses a byte recovers at the next gap. A byte that arrives with the receiver's overrun flag set is thrown away and does not count towards the packet. The output stage drives each colour to a fixed lane inside its group of four, to match the connector wiring: red, green and blue go to lanes 1, 2 and 3, and white goes to lane 0.

Top module: `rgbw_pkt_rx`

## Requirements
- R1: After reset, `wr_en` and `pkt_done` are low, and they stay low until an accepted packet completes.
- R2: A packet is ten accepted bytes in this order: byte 0 is the command, byte 1 is the logical channel, bytes 2..9 are red, green, blue and white. Each colour is two bytes with the high byte first, and `wr_data` carries the assembled 16-bit value.
- R3: A packet whose command byte is not 0x23 produces no write and no `pkt_done`.
- R4: A packet is accepted only when BOARD_OFFSET <= channel < BOARD_OFFSET + NUM_GROUPS. Outside that window it produces no write and no `pkt_done`.
- R5: For an accepted packet, base = (channel - BOARD_OFFSET) * 4. If the tenth byte is taken at clock edge t, the writes appear after edges t+1, t+2, t+3 and t+4, one per cycle: red to base+1, green to base+2, blue to base+3, white to base+0.
- R6: `pkt_done` is high for exactly one cycle, the cycle after the white write, and only for accepted packets.
- R7: The byte position returns to zero after every tenth accepted byte, whether or not the packet is accepted. Packets sent back to back with no idle cycles are each decoded.
- R8: A byte presented with `rx_overrun` high is dropped and does not advance the byte position.
- R9: Let LIMIT = TICK_DIV * TIMEOUT_TICKS. Suppose a byte is accepted at edge a. A byte accepted at edge a+LIMIT or later starts a new packet at position zero, and this holds even when it arrives in the very cycle the timeout fires. A byte accepted before edge a+LIMIT continues the current packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| rx_overrun | input | 1 | Receiver overrun flag for the byte in this cycle |
| wr_en | output | 1 | Raw-channel register write strobe |
| wr_addr | output | clog2(NUM_GROUPS*4) | Raw-channel register index |
| wr_data | output | 16 | Colour value to write |
| pkt_done | output | 1 | One-cycle pulse after the last write of a packet |

## Verification
Two functions can fall into the same clock edge: the inactivity timeout firing and a new byte arriving. In that case the byte must be taken as the first byte of a fresh packet. The bench provokes this by leaving exactly LIMIT-1 idle cycles after a partial packet before it starts a full packet. It then leaves LIMIT-2 idle cycles inside a packet, which must keep the frame going. A behavioural model counts idle cycles, predicts the write port on every clock, and also checks the number of writes per scenario.

// File: rtl/rgbw_rx_pkg.sv
package rgbw_rx_pkg;
    localparam int          PKT_BYTES = 10;
    localparam logic [7:0]  CMD_SET   = 8'h23;
    localparam int          POS_W     = $clog2(PKT_BYTES);
    localparam int          NUM_COLS  = 4;

    typedef logic [PKT_BYTES-1:0][7:0] pkt_bytes_t;
    typedef logic [15:0]               colour_t;
endpackage

// File: rtl/rgbw_idle_timer.sv
module rgbw_idle_timer #(
    parameter int TICK_DIV      = 1,
    parameter int TIMEOUT_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_seen,
    output logic expire
);
    localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int TICK_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;

    typedef struct packed {
        logic              run;
        logic [PRE_W-1:0]  pre;
        logic [TICK_W-1:0] tick;
    } tmr_t;

    tmr_t q, d;
    logic pre_wrap;

    generate
        if (TICK_DIV > 1) begin : g_prescale
            assign pre_wrap = (q.pre == PRE_W'(TICK_DIV - 1));
        end else begin : g_direct
            assign pre_wrap = 1'b1;
        end
    endgenerate

    assign expire = q.run && pre_wrap && (q.tick == TICK_W'(TIMEOUT_TICKS - 1));

    always_comb begin
        d = q;
        if (byte_seen) begin
            d.run  = 1'b1;
            d.pre  = '0;
            d.tick = '0;
        end else if (expire) begin
            d.run = 1'b0;
        end else if (q.run) begin
            if (pre_wrap) begin
                d.pre  = '0;
                d.tick = q.tick + 1'b1;
            end else begin
                d.pre = q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !byte_seen |=> !q.run) else $error("timer kept running"); // R9
endmodule

// File: rtl/rgbw_pkt_asm.sv
module rgbw_pkt_asm
    import rgbw_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_overrun,
    input  logic       expire,
    output logic       byte_ok,
    output logic       pkt_valid,
    output pkt_bytes_t pkt_bytes
);
    localparam logic [POS_W-1:0] LAST = POS_W'(PKT_BYTES - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        pkt_bytes_t       bytes;
        logic             pkt_valid;
    } asm_t;

    asm_t q, d;
    logic [POS_W-1:0] slot;

    assign byte_ok   = rx_valid && !rx_overrun;
    assign pkt_valid = q.pkt_valid;
    assign pkt_bytes = q.bytes;

    always_comb begin
        d           = q;
        d.pkt_valid = 1'b0;
        slot        = expire ? '0 : q.pos;
        if (byte_ok) begin
            d.bytes[slot] = rx_data;
            if (slot == LAST) begin
                d.pos       = '0;
                d.pkt_valid = 1'b1;
            end else begin
                d.pos = slot + 1'b1;
            end
        end else if (expire) begin
            d.pos = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.pos <= LAST) else $error("position out of range"); // R7
    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_overrun && !expire |=> $stable(q.pos)) else $error("overrun byte moved position"); // R8
    AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !rx_valid |=> q.pos == '0) else $error("timeout left position"); // R9
endmodule

// File: rtl/rgbw_wr_seq.sv
module rgbw_wr_seq
    import rgbw_rx_pkg::*;
#(
    parameter int BOARD_OFFSET = 0,
    parameter int NUM_GROUPS   = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 pkt_valid,
    input  pkt_bytes_t                           pkt_bytes,
    output logic                                 wr_en,
    output logic [$clog2(NUM_GROUPS*4)-1:0]      wr_addr,
    output logic [15:0]                          wr_data,
    output logic                                 pkt_done
);
    localparam int         GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int         AW = $clog2(NUM_GROUPS * 4);
    localparam logic [8:0] LO = 9'(BOARD_OFFSET);
    localparam logic [8:0] HI = 9'(BOARD_OFFSET + NUM_GROUPS);

    typedef struct packed {
        logic                         busy;
        logic [1:0]                   step;
        logic [AW-1:0]                base;
        logic [NUM_COLS-1:0][15:0]    vals;
        logic                         done;
    } seq_t;

    seq_t q, d;
    logic [8:0]    ch9, rel9;
    logic          hit;
    logic [1:0]    lane;
    logic [NUM_COLS-1:0][15:0] vals_in;

    assign ch9  = {1'b0, pkt_bytes[1]};
    assign rel9 = ch9 - LO;
    assign hit  = (pkt_bytes[0] == CMD_SET) && (ch9 >= LO) && (ch9 < HI);

    generate
        for (genvar k = 0; k < NUM_COLS; k++) begin : g_col
            assign vals_in[k] = {pkt_bytes[2 + 2*k], pkt_bytes[3 + 2*k]};
        end
    endgenerate

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.busy) begin
            if (q.step == 2'd3) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.step = q.step + 2'd1;
            end
        end else if (pkt_valid && hit) begin
            d.busy = 1'b1;
            d.step = 2'd0;
            d.base = AW'({rel9[GW-1:0], 2'b00});
            d.vals = vals_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lane     = q.step + 2'd1;
    assign wr_en    = q.busy;
    assign wr_addr  = q.base | AW'(lane);
    assign wr_data  = q.vals[q.step];
    assign pkt_done = q.done;

    AST_DONE_AFTER_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.busy && q.step == 2'd3)) else $error("done without fourth write"); // R6
    AST_NO_PKT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !q.busy) else $error("packet completed during writes"); // R7
    AST_BAD_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_bytes[0] != CMD_SET |=> !q.busy) else $error("bad command started writes"); // R3
    AST_START_FROM_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(pkt_valid)) else $error("writes without packet"); // R4
endmodule

// File: rtl/rgbw_pkt_rx.sv
module rgbw_pkt_rx
    import rgbw_rx_pkg::*;
#(
    parameter int BOARD_OFFSET  = 0,
    parameter int NUM_GROUPS    = 8,
    parameter int TICK_DIV      = 1,
    parameter int TIMEOUT_TICKS = 1000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rx_valid,
    input  logic [7:0]                      rx_data,
    input  logic                            rx_overrun,
    output logic                            wr_en,
    output logic [$clog2(NUM_GROUPS*4)-1:0] wr_addr,
    output logic [15:0]                     wr_data,
    output logic                            pkt_done
);
    logic       byte_ok;
    logic       expire;
    logic       pkt_valid;
    pkt_bytes_t pkt_bytes;

    rgbw_idle_timer #(
        .TICK_DIV      (TICK_DIV),
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_seen (byte_ok),
        .expire    (expire)
    );

    rgbw_pkt_asm u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_overrun (rx_overrun),
        .expire     (expire),
        .byte_ok    (byte_ok),
        .pkt_valid  (pkt_valid),
        .pkt_bytes  (pkt_bytes)
    );

    rgbw_wr_seq #(
        .BOARD_OFFSET (BOARD_OFFSET),
        .NUM_GROUPS   (NUM_GROUPS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .pkt_bytes (pkt_bytes),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pkt_done  (pkt_done)
    );
endmodule

// File: tb/tb_rgbw_pkt_rx.sv
`timescale 1ns/1ps
module tb_rgbw_pkt_rx;
    localparam int OFF   = 2;
    localparam int NG    = 8;
    localparam int DIV   = 2;
    localparam int TT    = 20;
    localparam int LIMIT = DIV * TT;
    localparam int AW    = $clog2(NG * 4);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_overrun = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [15:0]   wr_data;
    logic          pkt_done;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";
    int wr_cnt = 0;
    int done_cnt = 0;

    rgbw_pkt_rx #(
        .BOARD_OFFSET (OFF), .NUM_GROUPS (NG), .TICK_DIV (DIV), .TIMEOUT_TICKS (TT)
    ) dut (
        .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_data (rx_data),
        .rx_overrun (rx_overrun), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .pkt_done (pkt_done)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    int         m_pos, m_c, cyc;
    bit         m_run;
    logic [7:0] m_buf [10];
    int         exp_addr [int];
    int         exp_data [int];
    bit         exp_done [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_c = 0; m_run = 0; cyc = 0;
            exp_addr.delete(); exp_data.delete(); exp_done.delete();
        end else begin
            bit acc, ex;
            int p, g;
            cyc++;
            acc = rx_valid && !rx_overrun;
            ex  = m_run && (m_c == LIMIT - 1);
            p   = ex ? 0 : m_pos;
            if (acc) begin
                m_buf[p] = rx_data;
                if (p == 9) begin
                    m_pos = 0;
                    if (m_buf[0] == 8'h23 && int'(m_buf[1]) >= OFF && int'(m_buf[1]) < OFF + NG) begin
                        g = int'(m_buf[1]) - OFF;
                        exp_addr[cyc+1] = g*4 + 1; exp_data[cyc+1] = {m_buf[2], m_buf[3]};
                        exp_addr[cyc+2] = g*4 + 2; exp_data[cyc+2] = {m_buf[4], m_buf[5]};
                        exp_addr[cyc+3] = g*4 + 3; exp_data[cyc+3] = {m_buf[6], m_buf[7]};
                        exp_addr[cyc+4] = g*4;     exp_data[cyc+4] = {m_buf[8], m_buf[9]};
                        exp_done[cyc+5] = 1'b1;
                    end
                end else begin
                    m_pos = p + 1;
                end
                m_c = 0; m_run = 1;
            end else if (ex) begin
                m_pos = 0; m_run = 0;
            end else if (m_run) begin
                m_c++;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        bit ew, ed;
        ew = exp_addr.exists(cyc);
        ed = exp_done.exists(cyc);
        tests++;
        if (wr_en !== ew || pkt_done !== ed ||
            (ew && (int'(wr_addr) != exp_addr[cyc] || int'(wr_data) != exp_data[cyc]))) begin
            fails++;
            $display("FAIL %s cyc %0d: wr_en=%b addr=%0d data=%h done=%b, expected wr_en=%b addr=%0d data=%h done=%b",
                cur_req, cyc, wr_en, wr_addr, wr_data, pkt_done, ew,
                ew ? exp_addr[cyc] : 0, ew ? exp_data[cyc] : 0, ed);
        end
        if (wr_en === 1'b1) wr_cnt++;
        if (pkt_done === 1'b1) done_cnt++;
    end

    task automatic put(input logic [7:0] b, input logic ovr = 1'b0);
        rx_valid = 1'b1; rx_data = b; rx_overrun = ovr;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        rx_valid = 1'b0; rx_overrun = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pkt(input logic [7:0] cmd, input logic [7:0] ch,
                            input logic [15:0] r, input logic [15:0] g,
                            input logic [15:0] b, input logic [15:0] w);
        put(cmd); put(ch);
        put(r[15:8]); put(r[7:0]); put(g[15:8]); put(g[7:0]);
        put(b[15:8]); put(b[7:0]); put(w[15:8]); put(w[7:0]);
    endtask

    task automatic count_check(input string tag, input int ew, input int ed);
        idle(8);
        tests++;
        if (wr_cnt != ew || done_cnt != ed) begin
            fails++;
            $display("FAIL %s: writes=%0d done=%0d, expected writes=%0d done=%0d",
                tag, wr_cnt, done_cnt, ew, ed);
        end
        wr_cnt = 0; done_cnt = 0;
    endtask

    initial begin
        // R1: reset state, nothing written before a packet
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        count_check("R1", 0, 0);

        // R2 R5 R6: accepted packet, lowest channel
        cur_req = "R2/R5/R6";
        send_pkt(8'h23, 8'(OFF), 16'h1234, 16'h5678, 16'h9abc, 16'hdef0);
        count_check("R2", 4, 1);

        // R4 R5: highest channel in window
        cur_req = "R4/R5";
        send_pkt(8'h23, 8'(OFF + NG - 1), 16'hffff, 16'h0001, 16'h8000, 16'h7fff);
        count_check("R5", 4, 1);

        // R4: channel just below and just above the window
        cur_req = "R4";
        send_pkt(8'h23, 8'(OFF - 1), 16'h1111, 16'h2222, 16'h3333, 16'h4444);
        send_pkt(8'h23, 8'(OFF + NG), 16'h1111, 16'h2222, 16'h3333, 16'h4444);
        count_check("R4", 0, 0);

        // R3: wrong command byte
        cur_req = "R3";
        send_pkt(8'h24, 8'(OFF + 1), 16'haaaa, 16'hbbbb, 16'hcccc, 16'hdddd);
        count_check("R3", 0, 0);

        // R7: back-to-back packets, a rejected one between two accepted ones
        cur_req = "R7";
        send_pkt(8'h23, 8'(OFF + 3), 16'h0102, 16'h0304, 16'h0506, 16'h0708);
        send_pkt(8'h00, 8'(OFF + 3), 16'h0, 16'h0, 16'h0, 16'h0);
        send_pkt(8'h23, 8'(OFF + 4), 16'h1112, 16'h1314, 16'h1516, 16'h1718);
        count_check("R7", 8, 2);

        // R8: overrun bytes inside a packet are dropped
        cur_req = "R8";
        put(8'h23); put(8'(OFF + 5)); put(8'h77, 1'b1); put(8'hab); put(8'hcd);
        put(8'h99, 1'b1); put(8'h12); put(8'h34); put(8'h56); put(8'h78);
        put(8'h9a); put(8'hbc);
        count_check("R8", 4, 1);

        // R8: lone overrun byte does not start a packet
        put(8'h23, 1'b1);
        send_pkt(8'h23, 8'(OFF + 6), 16'hcafe, 16'hbeef, 16'hf00d, 16'hd00d);
        count_check("R8", 4, 1);

        // R9: long gap after a partial packet resynchronises framing
        cur_req = "R9";
        put(8'h23); put(8'(OFF)); put(8'h55); put(8'h66);
        idle(LIMIT + 5);
        send_pkt(8'h23, 8'(OFF + 2), 16'h2468, 16'h1357, 16'hace0, 16'hbdf1);
        count_check("R9", 4, 1);

        // R9: byte arrives on the very edge the timeout fires -> position zero
        put(8'h23); put(8'(OFF + 1)); put(8'h42);
        idle(LIMIT - 1);
        send_pkt(8'h23, 8'(OFF + 7), 16'h0f0f, 16'hf0f0, 16'h3c3c, 16'hc3c3);
        count_check("R9", 4, 1);

        // R9: gap one cycle short of the timeout keeps the frame
        put(8'h23); put(8'(OFF + 1)); put(8'hde);
        idle(LIMIT - 2);
        put(8'had); put(8'hbe); put(8'hef); put(8'h01); put(8'h23); put(8'h45); put(8'h67);
        count_check("R9", 4, 1);

        idle(LIMIT + 4);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule